// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

This block produces the serial clock for an SPI master. A reloadable down counter is decremented by one of two reference rates, and each time it runs out the internal clock level flips and the counter takes the programmed preload again. Both references reach the block as single-cycle enable pulses inside one system clock domain. One stands for the fast main reference (48 MHz nominal) and one for a slow 2 MHz reference. A source bit chooses between them. A preload of zero always uses the main reference, whatever the source bit says.

The clock runs only while the shift engine holds `xfer_active`. When no transfer is in progress, the counter is held at the preload value and the output rests at its idle level, which the polarity bit sets. Because the counter is loaded while idle, the first half period of a transfer always has full length. For each change of the serial clock, the block raises a one-cycle strobe that marks it as a leading edge (away from idle) or a trailing edge (back to idle). The shift engine uses these strobes to launch and capture data according to its phase setting.

Top module: `spi_sclk_gen`

## Requirements
- R1: With `div_preload` non-zero, `ref_sel` = 0 selects `main_tick` as the decrement rate and `ref_sel` = 1 selects `slow_tick`.
- R2: While active with `div_preload` = P ≥ 1, the serial clock changes level once every P selected ticks. Its period is therefore 2·P selected ticks, and it never changes on a cycle without a selected tick.
- R3: With `div_preload` = 0, the serial clock changes level on every `main_tick` while active, and `ref_sel` and `slow_tick` have no effect.
- R4: The counter is loaded from `div_preload` while idle. The first leading edge of a transfer therefore comes after exactly P selected ticks counted from the first active cycle (1 tick for P = 0).
- R5: From the cycle after `xfer_active` is sampled low, `sclk` equals `clk_pol` and no strobe is raised.
- R6: `clk_pol` = 0 gives an active-high clock (idle 0). `clk_pol` = 1 inverts the output (idle 1, active-low pulses).
- R7: `lead_stb` is high for exactly the cycle in which `sclk` moves to its active level, and `trail_stb` for exactly the cycle in which it returns to the idle level. The two are never high together.
- R8: After reset, `sclk` equals `clk_pol` and both strobes are low.
- R9: The default setting (`div_preload` = 2, `ref_sel` = 0) divides the main reference by 4, which gives 12 MHz from 48 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_tick | input | 1 | Enable pulse at the main reference rate |
| slow_tick | input | 1 | Enable pulse at the slow reference rate |
| ref_sel | input | 1 | Reference select: 0 main, 1 slow |
| div_preload | input | PRELOAD_W (6) | Reload value of the down counter |
| clk_pol | input | 1 | Idle level of the serial clock |
| xfer_active | input | 1 | High while the shift engine is transferring |
| sclk | output | 1 | Serial clock to the SPI device |
| lead_stb | output | 1 | One-cycle strobe on each leading edge |
| trail_stb | output | 1 | One-cycle strobe on each trailing edge |

## Verification
The assertions check on every cycle the relations that hold locally. The strobes never coincide and each matches the level `sclk` reaches. The clock rests at the polarity level after idle, holds still on cycles with no tick, and ignores the slow reference when the preload is zero. Only the bench's scenarios can show the counting behaviour: the half-period length for each preload and source, the tick count to the first edge, the default 12 MHz ratio, and the reset state. For these, a behavioural tick-counting model is compared against the outputs on every cycle, and the lead-to-lead intervals are measured.

// File: rtl/spi_sclk_pkg.sv
// Package: shared types for the SPI serial clock generator.
// Assumes a single system clock domain with reference rates given as enables.
package spi_sclk_pkg;

    // Reference source encoding as driven on ref_sel.
    typedef enum logic {
        REF_MAIN = 1'b0,
        REF_SLOW = 1'b1
    } ref_src_e;

    // Level of the raw (pre-polarity) generator output.
    typedef enum logic {
        LVL_IDLE   = 1'b0,
        LVL_ACTIVE = 1'b1
    } raw_lvl_e;

endpackage

// File: rtl/spi_ref_mux.sv
// Module: spi_ref_mux
// Chooses which reference enable decrements the divider. A zero preload
// forces the main reference and ignores the select bit.
// Assumes both tick inputs are single-cycle pulses in the system clock domain.
module spi_ref_mux
    import spi_sclk_pkg::*;
#(
    parameter int PRELOAD_W = 6
) (
    input  logic                 main_tick,
    input  logic                 slow_tick,
    input  logic                 ref_sel,
    input  logic [PRELOAD_W-1:0] div_preload,
    output logic                 sel_tick
);

    logic     preload_zero;
    ref_src_e src_eff;

    // Detect the zero preload that overrides the source select.
    always_comb preload_zero = (div_preload == '0);

    // Effective source after the zero-preload override.
    always_comb src_eff = preload_zero ? REF_MAIN : ref_src_e'(ref_sel);

    // Route the chosen enable to the divider.
    always_comb begin
        unique case (src_eff)
            REF_MAIN: sel_tick = main_tick;
            REF_SLOW: sel_tick = slow_tick;
            default:  sel_tick = main_tick;
        endcase
    end

endmodule

// File: rtl/spi_div_counter.sv
// Module: spi_div_counter
// Reloadable down counter. While idle it is held at the preload value.
// While running, each tick counts it down, and the tick that finds it at
// one or zero flags an underflow and reloads it.
// Assumes the preload is stable during a transfer.
module spi_div_counter #(
    parameter int PRELOAD_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 tick,
    input  logic [PRELOAD_W-1:0] div_preload,
    output logic                 underflow
);

    localparam logic [PRELOAD_W-1:0] CNT_ONE = PRELOAD_W'(1);

    logic [PRELOAD_W-1:0] cnt_q;
    logic                 last_step;

    // The current count is the final one of the half period.
    always_comb last_step = (cnt_q <= CNT_ONE);

    // Underflow occurs on a tick at the final count while running.
    always_comb underflow = run && tick && last_step;

    // Count state: preload while idle, decrement or reload while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= div_preload;
        end else if (tick) begin
            cnt_q <= last_step ? div_preload : cnt_q - CNT_ONE;
        end
    end

endmodule

// File: rtl/spi_edge_gen.sv
// Module: spi_edge_gen
// Toggles the raw clock level on each underflow. It forces the level back to
// idle whenever the transfer stops, raises the lead/trail strobes together
// with the level they produce, and applies the polarity inversion.
// Assumes the underflow input is already qualified by run.
module spi_edge_gen
    import spi_sclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic underflow,
    input  logic clk_pol,
    output logic sclk,
    output logic lead_stb,
    output logic trail_stb
);

    raw_lvl_e lvl_q;
    raw_lvl_e lvl_nxt;
    logic     lead_q;
    logic     trail_q;

    // Next raw level: idle when stopped, flipped on underflow.
    always_comb begin
        if (!run) begin
            lvl_nxt = LVL_IDLE;
        end else if (underflow) begin
            lvl_nxt = (lvl_q == LVL_IDLE) ? LVL_ACTIVE : LVL_IDLE;
        end else begin
            lvl_nxt = lvl_q;
        end
    end

    // Level and strobe registers, the strobes aligned with the new level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= LVL_IDLE;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
        end else begin
            lvl_q   <= lvl_nxt;
            lead_q  <= run && underflow && (lvl_q == LVL_IDLE);
            trail_q <= run && underflow && (lvl_q == LVL_ACTIVE);
        end
    end

    // Polarity: the idle level of the pin equals clk_pol.
    always_comb sclk = (lvl_q == LVL_ACTIVE) ^ clk_pol;

    // Strobe outputs.
    always_comb lead_stb  = lead_q;
    always_comb trail_stb = trail_q;

endmodule

// File: rtl/spi_sclk_gen.sv
// Module: spi_sclk_gen (top)
// SPI serial clock generator: reference mux, reloadable divider and edge
// generator in series. Half period = preload selected ticks (one main tick
// for a zero preload). The clock is gated to its idle level outside transfers.
// Assumes register decoding and the reference sources are external.
module spi_sclk_gen #(
    parameter int PRELOAD_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 main_tick,
    input  logic                 slow_tick,
    input  logic                 ref_sel,
    input  logic [PRELOAD_W-1:0] div_preload,
    input  logic                 clk_pol,
    input  logic                 xfer_active,
    output logic                 sclk,
    output logic                 lead_stb,
    output logic                 trail_stb
);

    logic sel_tick;
    logic underflow;

    // Reference selection.
    spi_ref_mux #(.PRELOAD_W(PRELOAD_W)) i_ref_mux (
        .main_tick   (main_tick),
        .slow_tick   (slow_tick),
        .ref_sel     (ref_sel),
        .div_preload (div_preload),
        .sel_tick    (sel_tick)
    );

    // Divider.
    spi_div_counter #(.PRELOAD_W(PRELOAD_W)) i_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (xfer_active),
        .tick        (sel_tick),
        .div_preload (div_preload),
        .underflow   (underflow)
    );

    // Output level and strobes.
    spi_edge_gen i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (xfer_active),
        .underflow (underflow),
        .clk_pol   (clk_pol),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

endmodule

// File: rtl/spi_sclk_gen_chk.sv
// Module: spi_sclk_gen_chk
// Port-level checker for spi_sclk_gen, attached with bind below.
module spi_sclk_gen_chk #(
    parameter int PRELOAD_W = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 main_tick,
    input logic                 slow_tick,
    input logic                 ref_sel,
    input logic [PRELOAD_W-1:0] div_preload,
    input logic                 clk_pol,
    input logic                 xfer_active,
    input logic                 sclk,
    input logic                 lead_stb,
    input logic                 trail_stb
);

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));

    p_lead_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> (sclk != clk_pol));

    p_trail_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (sclk == clk_pol));

    p_idle_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> (sclk == clk_pol) && !lead_stb && !trail_stb);

    p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !main_tick && !slow_tick)
            |=> ($stable(sclk) || (clk_pol != $past(clk_pol))));

    p_zero_ignores_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && (div_preload == '0) && !main_tick)
            |=> !lead_stb && !trail_stb);

    p_slow_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && (div_preload != '0) && ref_sel && !slow_tick)
            |=> !lead_stb && !trail_stb);

endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.PRELOAD_W(PRELOAD_W)) i_chk (.*);

// File: tb/test_spi_sclk_gen.sv
// Bench for spi_sclk_gen: per-cycle behavioural tick-count model plus
// measured edge intervals for several preload/source/polarity settings.
module test_spi_sclk_gen;

    localparam int CLK_PERIOD = 10;
    localparam int MAIN_GAP   = 2;
    localparam int SLOW_GAP   = 48;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_tick = 1'b0;
    logic       slow_tick = 1'b0;
    logic       ref_sel = 1'b0;
    logic [5:0] div_preload = 6'd2;
    logic       clk_pol = 1'b0;
    logic       xfer_active = 1'b0;
    logic       sclk;
    logic       lead_stb;
    logic       trail_stb;

    int checks = 0;
    int failures = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    spi_sclk_gen i_spi_sclk_gen (
        .clk, .rst_n, .main_tick, .slow_tick, .ref_sel, .div_preload,
        .clk_pol, .xfer_active, .sclk, .lead_stb, .trail_stb
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    // Reference pulse generation, driven just after each rising edge.
    initial begin
        int n = 0;
        forever begin
            @(posedge clk); #2;
            main_tick = (n % MAIN_GAP) == 0;
            slow_tick = (n % SLOW_GAP) == 0;
            n++;
        end
    end

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural model: counts selected ticks per half period.
    int m_seen = 0;
    bit m_lvl = 0, m_lead = 0, m_trail = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_seen = 0; m_lvl = 0; m_lead = 0; m_trail = 0;
        end else begin
            m_lead = 0; m_trail = 0;
            if (!xfer_active) begin
                m_seen = 0; m_lvl = 0;
            end else begin
                bit t;
                int half;
                t = (div_preload == 0 || !ref_sel) ? main_tick : slow_tick;
                half = (div_preload == 0) ? 1 : int'(div_preload);
                if (t) begin
                    m_seen++;
                    if (m_seen >= half) begin
                        m_seen = 0;
                        m_lvl = !m_lvl;
                        m_lead = m_lvl;
                        m_trail = !m_lvl;
                    end
                end
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check(sclk === (m_lvl ^ clk_pol), xfer_active ? "R2" : "R5",
                  "sclk vs model", int'(sclk), int'(m_lvl ^ clk_pol));
            check(lead_stb === m_lead, "R7", "lead_stb vs model",
                  int'(lead_stb), int'(m_lead));
            check(trail_stb === m_trail, "R7", "trail_stb vs model",
                  int'(trail_stb), int'(m_trail));
        end
    end

    task automatic drive_cfg(int p, bit src, bit pol);
        @(posedge clk); #2;
        xfer_active = 1'b0;
        div_preload = 6'(p);
        ref_sel     = src;
        clk_pol     = pol;
        repeat (3) @(posedge clk);
    endtask

    // Run one transfer; check ticks to first edge, lead-to-lead period,
    // active level at the leading edge and the idle state afterwards.
    task automatic run_xfer(int p, bit src, bit pol, int exp_period, string tag);
        int ticks = 0;
        int cyc = 0;
        int guard = 0;
        int exp_first;
        drive_cfg(p, src, pol);
        exp_first = (p == 0) ? 1 : p;
        @(posedge clk); #2;
        xfer_active = 1'b1;
        // R4: count selected ticks until first lead strobe.
        forever begin
            @(negedge clk);
            if (lead_stb) break;
            if ((p == 0 || !src) ? main_tick : slow_tick) ticks++;
            if (++guard > 20000) break;
        end
        check(ticks == exp_first, "R4", "ticks to first edge", ticks, exp_first);
        // R6: active level is the inverse of the polarity bit.
        check(sclk == !pol, "R6", "active level", int'(sclk), int'(!pol));
        // Period between leading edges.
        forever begin
            @(negedge clk);
            cyc++;
            if (lead_stb || cyc > 20000) break;
        end
        check(cyc == exp_period, tag, "lead-to-lead cycles", cyc, exp_period);
        @(posedge clk); #2;
        xfer_active = 1'b0;
        repeat (2) @(negedge clk);
        check(sclk == pol && !lead_stb && !trail_stb, "R5", "idle rest level",
              int'(sclk), int'(pol));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #3;
        // R8: reset state.
        check(sclk == clk_pol && !lead_stb && !trail_stb, "R8", "reset state",
              int'(sclk), int'(clk_pol));
        @(posedge clk); #2;
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (3) @(posedge clk);

        run_xfer(2, 0, 0, 4 * MAIN_GAP, "R9");          // default 12 MHz ratio
        run_xfer(1, 0, 0, 2 * MAIN_GAP, "R2");
        run_xfer(3, 0, 1, 6 * MAIN_GAP, "R6");
        run_xfer(3, 1, 0, 6 * SLOW_GAP, "R1");
        run_xfer(1, 1, 1, 2 * SLOW_GAP, "R1");
        run_xfer(0, 1, 0, 2 * MAIN_GAP, "R3");          // select ignored
        run_xfer(0, 0, 1, 2 * MAIN_GAP, "R3");
        run_xfer(63, 1, 0, 126 * SLOW_GAP, "R2");
        run_xfer(5, 0, 0, 10 * MAIN_GAP, "R2");

        // R5: polarity flip while idle moves the rest level at once.
        @(posedge clk); #2;
        clk_pol = 1'b1;
        @(negedge clk);
        check(sclk == 1'b1, "R5", "idle follows clk_pol", int'(sclk), 1);

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule